// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Bit-Order Select

This block turns one data word per accepted request into an asynchronous serial frame on a single output line. A frame is a low start bit, the data bits, an optional parity bit and a high stop bit. The line rests high between frames. The bit period comes from a reload divider. That divider counts either every system clock or every eighth system clock, and its output is divided by 16 once more.

The data word is offered through a valid/ready handshake. The following settings are sampled together with the word at acceptance: data order (least or most significant bit first), parity enable and sense, data inversion, count-source select and the 8-bit divider setting n. Every bit therefore lasts 16 × (n + 1) × P system clocks, where P is 1 or 8. Example: with a 16 MHz clock, P = 1 and n = 103, the line runs at about 9615 bit/s. With P = 8 and the same n, it runs at about 1202 bit/s. A busy flag covers the frame from the start bit to the end of the stop bit.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_o` is 1, `busy_o` is 0 and `ready_o` is 1.
- R2: A word is accepted on a rising clock edge where `valid_i` and `ready_o` are both 1. In the next cycle `busy_o` is 1, `ready_o` is 0 and `tx_o` is 0, which is the start bit.
- R3: Each bit of the frame lasts exactly 16 × (n + 1) × P clocks. n is `div_n_i` and P is 1 when `src_sel_i` = 0 and 8 when `src_sel_i` = 1. The line does not change within a bit.
- R4: The frame is sent in this order: start bit (0), the 8 data bits, the parity bit (only when `par_en_i` = 1), and the stop bit (1).
- R5: With `msb_first_i` = 0 the data goes out bit 0 first and bit 7 last. With `msb_first_i` = 1 it goes out bit 7 first and bit 0 last. Most-significant-first order exists only for 8-bit data words.
- R6: With `inv_i` = 1 every data bit is sent complemented. Start, stop and the parity rule are unaffected, and parity is computed over the complemented bits as they appear on the line.
- R7: With `par_odd_i` = 0 the parity bit makes the number of ones among the sent data bits and the parity bit even. With `par_odd_i` = 1 it makes that number odd.
- R8: `busy_o` stays 1 from the cycle after acceptance through the last clock of the stop bit. It falls exactly (10 + par_en) × 16 × (n + 1) × P clocks after the accepting edge.
- R9: The data word and all settings are captured at acceptance. Changes to the data and settings inputs, and pulses on `valid_i`, while a frame is in progress have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Count source: 0 = clock, 1 = clock / 8 |
| div_n_i | input | 8 | Reload divider setting n |
| msb_first_i | input | 1 | 1 = send bit 7 first |
| par_en_i | input | 1 | 1 = append parity bit |
| par_odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| inv_i | input | 1 | 1 = complement data bits |
| data_i | input | 8 | Word to send |
| valid_i | input | 1 | Request to send `data_i` |
| ready_o | output | 1 | Ready to accept a word |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
Several properties are checked on every cycle. The line rests high outside a frame. Acceptance is always followed by the start bit. The line holds steady between bit boundaries. The divider count never passes n. Busy only falls at the end of the stop bit, and the captured settings stay frozen while a frame runs. The remaining behaviour is shown only by the bench scenarios: the exact bit duration for both count sources, the data order, inversion, parity values and the total frame length. Each of these needs the expected line value at the centre of every bit and the exact cycle in which busy falls. The bench compares these against its own frame model, under random words and settings and under directed cases with a large n.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DIV_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic             src_div8;
    logic [DIV_W-1:0] div_n;
    logic             msb_first;
    logic             par_en;
    logic             par_odd;
    logic             inv;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned PRE_DIV = 8,
  parameter int unsigned DIV_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             div8_i,
  input  logic [DIV_W-1:0] div_n_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic             src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
    end else if (!en_i || pre_cnt_q == PRE_W'(PRE_DIV - 1)) begin
      pre_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  assign src_tick = div8_i ? (pre_cnt_q == PRE_W'(PRE_DIV - 1)) : 1'b1;
  assign tick_o   = en_i && src_tick && (div_cnt_q == div_n_i);

  // up-counter compared against n: no stale reload at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      div_cnt_q <= '0;
    end else if (src_tick) begin
      div_cnt_q <= div_cnt_q + 1'b1;
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (div_cnt_q <= div_n_i));

  // R3
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div8_i) |-> (pre_cnt_q == PRE_W'(PRE_DIV - 1)));
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              tx_o,
  output tx_cfg_t           cfg_o
);
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q, state_d;
  logic [OVS_W-1:0]  ovs_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  tx_cfg_t           cfg_q;
  logic              accept, bit_end, busy_q;
  logic              ord_bit, line_bit, par_bit;

  assign busy_q  = (state_q != ST_IDLE);
  assign ready_o = !busy_q;
  assign busy_o  = busy_q;
  assign accept  = valid_i && !busy_q;
  assign bit_end = tick_i && (ovs_q == OVS_W'(OVS - 1));
  assign cfg_o   = cfg_q;

  generate
    if (DATA_W == 8) begin : g_order
      assign ord_bit = cfg_q.msb_first ? data_q[DATA_W-1-int'(idx_q)] : data_q[idx_q];
    end else begin : g_lsb_only
      assign ord_bit = data_q[idx_q];
    end
  endgenerate

  assign line_bit = ord_bit ^ cfg_q.inv;
  assign par_bit  = (^(data_q ^ {DATA_W{cfg_q.inv}})) ^ cfg_q.par_odd;

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = line_bit;
      ST_PAR:   tx_o = par_bit;
      default:  tx_o = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_START;
      ST_START: if (bit_end) state_d = ST_DATA;
      ST_DATA:  if (bit_end && idx_q == IDX_W'(DATA_W - 1))
                  state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
      ST_PAR:   if (bit_end) state_d = ST_STOP;
      ST_STOP:  if (bit_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovs_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        data_q <= data_i;
        cfg_q  <= cfg_i;
        ovs_q  <= '0;
        idx_q  <= '0;
      end else if (tick_i) begin
        ovs_q <= ovs_q + 1'b1;
        if (bit_end && state_q == ST_DATA) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  // R2
  accept_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_o && !ready_o && !tx_o));

  // R3
  tx_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !bit_end) |=> $stable(tx_o));

  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(state_q) == ST_STOP));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(cfg_q) && $stable(data_q)));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OVS     = 16,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_sel_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic              msb_first_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              inv_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              busy_o
);
  tx_cfg_t cfg_in, cfg_act;
  logic    tick;

  always_comb begin
    cfg_in.src_div8  = src_sel_i;
    cfg_in.div_n     = div_n_i;
    cfg_in.msb_first = msb_first_i;
    cfg_in.par_en    = par_en_i;
    cfg_in.par_odd   = par_odd_i;
    cfg_in.inv       = inv_i;
  end

  uart_tx_baud #(
    .PRE_DIV (PRE_DIV),
    .DIV_W   (DIV_W)
  ) baud_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_o),
    .div8_i  (cfg_act.src_div8),
    .div_n_i (cfg_act.div_n),
    .tick_o  (tick)
  );

  uart_tx_frame #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) frame_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .valid_i (valid_i),
    .data_i  (data_i),
    .cfg_i   (cfg_in),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .tx_o    (tx_o),
    .cfg_o   (cfg_act)
  );
endmodule

// File: tb/uart_tx_core_tb_top.sv
`timescale 1ns/1ps
module uart_tx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_sel = 1'b0, msb_first = 1'b0, par_en = 1'b0, par_odd = 1'b0, inv = 1'b0;
  logic [7:0] div_n = 8'd0, data = 8'd0;
  logic       valid = 1'b0;
  logic       ready, tx, busy;
  int         n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_tx_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .div_n_i(div_n),
    .msb_first_i(msb_first), .par_en_i(par_en), .par_odd_i(par_odd), .inv_i(inv),
    .data_i(data), .valid_i(valid), .ready_o(ready), .tx_o(tx), .busy_o(busy)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected line bit k of a frame (R4, R5, R6, R7)
  function automatic logic exp_bit(int k, logic [7:0] d, logic msb, logic pe,
                                   logic po, logic iv);
    logic [7:0] sent;
    for (int i = 0; i < 8; i++) sent[i] = (msb ? d[7-i] : d[i]) ^ iv;
    if (k == 0) return 1'b0;
    if (k <= 8) return sent[k-1];
    if (k == 9 && pe) return (^sent) ^ po;
    return 1'b1;
  endfunction

  task automatic send(input logic [7:0] d, input logic ss, input logic [7:0] n,
                      input logic msb, input logic pe, input logic po, input logic iv);
    int p, b, l;
    string tag;
    p = ss ? 8 : 1;
    b = 16 * (int'(n) + 1) * p;
    l = (10 + int'(pe)) * b;
    while (!ready) begin @(posedge clk); #1; end
    data = d; src_sel = ss; div_n = n; msb_first = msb; par_en = pe; par_odd = po; inv = iv;
    valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0;
    // R9: scramble inputs during the frame
    {src_sel, msb_first, par_en, par_odd, inv} = 5'($urandom);
    data = 8'($urandom); div_n = 8'($urandom);
    check("R2", busy, 1'b1, "busy after accept");
    check("R2", ready, 1'b0, "ready after accept");
    check("R2", tx, 1'b0, "start bit");
    for (int c = 1; c <= l; c++) begin
      valid = (c == 2 * b) ? 1'b1 : 1'b0;  // R9 stray request mid-frame
      @(posedge clk); #1;
      if (c % b == b / 2 && c < l) begin
        int k = c / b;
        tag = (k == 0) ? "R4" : (k <= 8) ? (msb ? "R5" : "R4") : (k == 9 && pe) ? "R7" : "R4";
        if (iv && k >= 1 && k <= 8) tag = "R6";
        check(tag, tx, exp_bit(k, d, msb, pe, po, iv), $sformatf("bit %0d mid (R3 timing)", k));
      end
      if (c == l - 1) check("R8", busy, 1'b1, "busy in last stop cycle");
      if (c == l) begin
        check("R8", busy, 1'b0, "busy falls at frame end");
        check("R1", tx, 1'b1, "idle line after frame");
        check("R1", ready, 1'b1, "ready after frame");
      end
    end
    valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", tx, 1'b1, "reset line");
    check("R1", busy, 1'b0, "reset busy");
    check("R1", ready, 1'b1, "reset ready");
    // directed corners
    send(8'h01, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h01, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'hA5, 1'b0, 8'd103, 1'b1, 1'b1, 1'b1, 1'b0);
    send(8'h3C, 1'b1, 8'd12, 1'b0, 1'b1, 1'b0, 1'b1);
    send(8'h00, 1'b1, 8'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    send(8'hFF, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    // random frames
    for (int i = 0; i < 14; i++) begin
      send(8'($urandom), 1'($urandom), 8'($urandom_range(0, 3)), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
      if (i % 3 == 0) begin
        repeat (3) begin @(posedge clk); #1; check("R1", tx, 1'b1, "idle gap"); end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule